// File: doc/BRIEF.md
# Slow-Peripheral Bus Bridge

This block sits between a fast bus master and older peripherals that can only move data in step with a slow, shared clock. It divides the master clock to make that slow clock, `e_clk`, which runs without pause from reset onward. `e_clk` has an uneven split: high for part of the period and low for the rest.

A transfer starts when the master holds its active-low strobe low. The bridge then waits for the addressed peripheral to answer on its active-low "present" line. Once the answer arrives, the bridge stops counting on the fast clock and waits for the next rising edge of `e_clk`. On that edge it drives its active-low "memory cycle valid" line. It captures read data at the falling edge of `e_clk`, and on the following fast clock it releases that line and pulses completion to the master. If no peripheral answers within a set number of clocks, the bridge pulses a bus-error line instead, so the master can run exception handling.

On the master side the strobe works as the valid signal and the one-clock `mst_done` or `mst_berr` pulse works as ready. The master must keep the address, direction and write data stable while the strobe is low. It cannot stall completion: `mst_rdata` is valid in the cycle of the `mst_done` pulse. Every cycle is closed by raising the strobe, and a new cycle needs a fresh low strobe. All master-side inputs are taken to be in the `clk` domain.

Top module: `slowbus_bridge`

## Requirements
- R1: `e_clk` repeats every E_DIV (10) clocks. In each period it is high for E_HI (4) clocks and then low for the remaining 6. The first period after reset begins with the high phase, including the cycle that reset is released.
- R2: During and straight after reset, `e_clk` is 1, `per_vma_n` is 1, and `mst_berr` and `mst_done` are 0.
- R3: An idle bridge accepts a cycle on the clock edge that samples `mst_as_n` low. While `per_vma_n` is low, `per_addr`, `per_rw` (1 = read) and `per_wdata` equal the master's address, direction and write data.
- R4: Suppose `per_vpa_n` is sampled high on every one of the VPA_TIMEOUT (12) edges after the accepting edge. Then `mst_berr` is 1 for exactly the cycle after the last of those edges, and `per_vma_n` stays high. A `per_vpa_n` low seen on that last edge still completes the cycle normally.
- R5: After the peripheral answers, `per_vma_n` goes low on the edge where `e_clk` rises, never at any other point in the `e_clk` period.
- R6: Read data is taken from `per_rdata` on the edge where `e_clk` falls while `per_vma_n` is low. That value appears on `mst_rdata`.
- R7: On the next edge, `per_vma_n` returns high and `mst_done` is 1 for one clock.
- R8: After `mst_done` or `mst_berr`, the bridge starts no new cycle while `mst_as_n` stays low. It waits for the strobe to go high.
- R9: If `mst_as_n` is sampled high on any edge during a cycle, `per_vma_n` is high after that edge, the cycle is dropped, and no `mst_done` follows.
- R10: `mst_done` and `mst_berr` are each single-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_as_n | input | 1 | Master strobe, low while a cycle is requested |
| mst_rw | input | 1 | Master direction, 1 = read |
| mst_addr | input | AW | Master address |
| mst_wdata | input | DW | Master write data |
| mst_rdata | output | DW | Captured read data |
| mst_done | output | 1 | One-clock completion pulse |
| mst_berr | output | 1 | One-clock pulse when no peripheral answered |
| e_clk | output | 1 | Divided slow clock for the peripherals |
| per_vpa_n | input | 1 | Peripheral "present and ready", active low |
| per_vma_n | output | 1 | Bridge "memory cycle valid", active low |
| per_rw | output | 1 | Direction to the peripheral |
| per_addr | output | AW | Address to the peripheral |
| per_wdata | output | DW | Write data to the peripheral |
| per_rdata | input | DW | Read data from the peripheral |

## Verification
The bench checks the phase of every `per_vma_n` fall against its own count of `e_clk`. A bridge that asserts the line as soon as the peripheral answers, instead of waiting for the rising edge, is caught. The peripheral model drives valid data only while `e_clk` is high, so capturing one edge late returns a junk word in place of the expected one. The bench sends an answer on the very last edge inside the timeout window. An off-by-one timer then either raises a false bus error or completes a cycle that should have failed. The bench also drops the strobe during a transfer and holds it low after completion, which exposes a bridge that leaves `per_vma_n` low or retriggers on its own.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITVPA,
    ST_SYNC,
    ST_XFER,
    ST_FIN,
    ST_HOLD
  } bst_t;
endpackage

// File: rtl/bridge_eclk.sv
module bridge_eclk #(
  parameter int DIV = 10,
  parameter int HI  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic e_clk,
  output logic rise_next,
  output logic fall_next
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx    = (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
  assign rise_next = (cnt == CW'(DIV - 1));
  assign fall_next = (cnt == CW'(HI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      e_clk <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      e_clk <= (cnt_nx < CW'(HI));
    end
  end
endmodule

// File: rtl/bridge_watch.sv
module bridge_watch #(
  parameter int TO = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(TO + 1);

  logic [TW-1:0] timer;

  assign expire = run && (timer == TW'(TO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      timer <= '0;
    else if (!run)   timer <= '0;
    else if (!expire) timer <= timer + TW'(1);
  end
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_n,
  input  logic          vpa_n,
  input  logic          rise_next,
  input  logic          fall_next,
  input  logic          expire,
  input  logic [DW-1:0] per_rdata,
  output logic          vma_n,
  output logic          done,
  output logic          berr,
  output logic [DW-1:0] rdata,
  output logic          in_wait
);
  bst_t st;

  assign in_wait = (st == ST_WAITVPA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      vma_n <= 1'b1;
      done  <= 1'b0;
      berr  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      berr <= 1'b0;
      if (as_n && st != ST_IDLE) begin
        st    <= ST_IDLE;
        vma_n <= 1'b1;
      end else begin
        case (st)
          ST_IDLE:    if (!as_n) st <= ST_WAITVPA;
          ST_WAITVPA: begin
            if (!vpa_n) st <= ST_SYNC;
            else if (expire) begin
              berr <= 1'b1;
              st   <= ST_HOLD;
            end
          end
          ST_SYNC: if (rise_next) begin
            vma_n <= 1'b0;
            st    <= ST_XFER;
          end
          ST_XFER: if (fall_next) begin
            rdata <= per_rdata;
            st    <= ST_FIN;
          end
          ST_FIN: begin
            vma_n <= 1'b1;
            done  <= 1'b1;
            st    <= ST_HOLD;
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/slowbus_bridge.sv
module slowbus_bridge #(
  parameter int AW          = 23,
  parameter int DW          = 16,
  parameter int E_DIV       = 10,
  parameter int E_HI        = 4,
  parameter int VPA_TIMEOUT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mst_as_n,
  input  logic          mst_rw,
  input  logic [AW-1:0] mst_addr,
  input  logic [DW-1:0] mst_wdata,
  output logic [DW-1:0] mst_rdata,
  output logic          mst_done,
  output logic          mst_berr,
  output logic          e_clk,
  input  logic          per_vpa_n,
  output logic          per_vma_n,
  output logic          per_rw,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata
);
  logic rise_next, fall_next, expire, in_wait;

  assign per_rw    = mst_rw;
  assign per_addr  = mst_addr;
  assign per_wdata = mst_wdata;

  bridge_eclk #(.DIV(E_DIV), .HI(E_HI)) u_eclk (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk),
    .rise_next(rise_next), .fall_next(fall_next)
  );

  bridge_watch #(.TO(VPA_TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .expire(expire)
  );

  bridge_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .as_n(mst_as_n), .vpa_n(per_vpa_n),
    .rise_next(rise_next), .fall_next(fall_next), .expire(expire),
    .per_rdata(per_rdata), .vma_n(per_vma_n), .done(mst_done),
    .berr(mst_berr), .rdata(mst_rdata), .in_wait(in_wait)
  );
endmodule

// File: rtl/slowbus_bridge_chk.sv
module slowbus_bridge_chk #(
  parameter int DIV = 10,
  parameter int HI  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mst_as_n,
  input logic mst_done,
  input logic mst_berr,
  input logic e_clk,
  input logic per_vma_n
);
  logic       e_d;
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_d     <= 1'b1;
      run_len <= 8'd0;
    end else begin
      e_d     <= e_clk;
      run_len <= (e_clk == e_d) ? run_len + 8'd1 : 8'd1;
    end
  end

  // R1
  e_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clk != e_d) |-> (run_len == (e_d ? 8'(HI) : 8'(DIV - HI))));

  // R5
  vma_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_vma_n) |-> $rose(e_clk));

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_done |-> (per_vma_n && $past(!per_vma_n)));

  // R9
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_as_n |=> per_vma_n);

  // R4
  berr_no_vma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_berr |-> per_vma_n);

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_done || mst_berr) |=> !(mst_done || mst_berr));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mst_done && mst_berr));
endmodule

bind slowbus_bridge slowbus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mst_as_n(mst_as_n), .mst_done(mst_done),
  .mst_berr(mst_berr), .e_clk(e_clk), .per_vma_n(per_vma_n)
);

// File: tb/slowbus_bridge_test.sv
module slowbus_bridge_test;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int TO = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          mst_as_n = 1'b1, mst_rw = 1'b1;
  logic [AW-1:0] mst_addr = '0;
  logic [DW-1:0] mst_wdata = '0, mst_rdata;
  logic          mst_done, mst_berr, e_clk, per_vma_n, per_rw;
  logic          per_vpa_n = 1'b1;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata, per_rdata;
  logic [DW-1:0] cur_data = '0;

  // peripheral model: data valid only while selected and E high
  assign per_rdata = (!per_vma_n && e_clk) ? cur_data : DW'(16'hDEAD);

  slowbus_bridge #(.AW(AW), .DW(DW), .E_DIV(10), .E_HI(4), .VPA_TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .mst_as_n(mst_as_n), .mst_rw(mst_rw),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_rdata(mst_rdata),
    .mst_done(mst_done), .mst_berr(mst_berr), .e_clk(e_clk),
    .per_vpa_n(per_vpa_n), .per_vma_n(per_vma_n), .per_rw(per_rw),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  int checks = 0, errors = 0, pc = 0;
  bit berr_ok = 0;
  logic prev_vma = 1'b1;
  logic [DW-1:0] expq[$];

  always @(posedge clk) if (!rst_n) pc <= 0; else pc <= pc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      chk(e_clk == ((pc % 10) < 4), "R1", "e_clk phase", e_clk, int'((pc % 10) < 4));
      if (prev_vma && !per_vma_n)
        chk(pc % 10 == 0, "R5", "vma fall phase", pc % 10, 0);
      if (mst_done) begin
        chk(per_vma_n && !prev_vma, "R7", "vma release with done", per_vma_n, 1);
        chk(pc % 10 == 5, "R7", "done phase", pc % 10, 5);
        if (expq.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk(mst_rdata == e, "R6", "read data", mst_rdata, e);
        end
      end
      if (mst_berr && !berr_ok) chk(0, "R4", "unexpected bus error", 1, 0);
      if (mst_berr && mst_done) chk(0, "R10", "done and berr together", 1, 0);
      prev_vma = per_vma_n;
    end
  end

  // driver: one transfer; vpa set after sample number dly
  task automatic do_xfer(logic [AW-1:0] a, logic [DW-1:0] wd, logic rw,
                         logic [DW-1:0] rd, int dly, int hold);
    bit fwd = 0, got = 0;
    @(negedge clk);
    mst_addr = a; mst_wdata = wd; mst_rw = rw; cur_data = rd;
    expq.push_back(rd);
    mst_as_n = 1'b0;
    if (dly == 0) per_vpa_n = 1'b0;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (k == dly) per_vpa_n = 1'b0;
      if (!per_vma_n && !fwd) begin
        fwd = 1;
        chk(per_addr == a, "R3", "addr forward", per_addr, a);
        chk(per_rw == rw, "R3", "rw forward", per_rw, rw);
        chk(per_wdata == wd, "R3", "wdata forward", per_wdata, wd);
      end
      if (mst_done) begin got = 1; break; end
    end
    chk(got, "R7", "completion seen", got, 1);
    per_vpa_n = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(per_vma_n && !mst_done, "R8", "no retrigger while strobe low", per_vma_n, 1);
    end
    mst_as_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(e_clk == 1'b1, "R2", "e_clk in reset", e_clk, 1);
    chk(per_vma_n == 1'b1, "R2", "vma in reset", per_vma_n, 1);
    chk(!mst_berr && !mst_done, "R2", "pulses in reset", mst_berr | mst_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_xfer(23'h000123, 16'h0000, 1'b1, 16'hA5A5, 0, 0);
    do_xfer(23'h7F0040, 16'h1234, 1'b0, 16'h5A5A, 3, 0);
    // R4 boundary: answer seen on last edge in window
    do_xfer(23'h001000, 16'h0000, 1'b1, 16'h0F0F, TO, 0);
    for (int i = 1; i <= 6; i++)
      do_xfer(23'(i * 37), 16'(i * 7), 1'(i % 2), 16'(16'h1111 * i), i, 0);

    // R4 timeout, R8 no retry while strobe held
    berr_ok = 1;
    @(negedge clk);
    mst_as_n = 1'b0;
    for (int k = 1; k <= TO + 8; k++) begin
      @(negedge clk);
      chk(mst_berr == (k == TO + 1), "R4", "berr timing", mst_berr, int'(k == TO + 1));
      chk(per_vma_n && !mst_done, "R4", "no transfer on timeout", per_vma_n, 1);
    end
    mst_as_n = 1'b1;
    @(negedge clk);
    berr_ok = 0;

    // R9 abort during transfer
    @(negedge clk);
    mst_as_n = 1'b0; per_vpa_n = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!per_vma_n) break;
    end
    mst_as_n = 1'b1; per_vpa_n = 1'b1;
    @(negedge clk);
    chk(per_vma_n, "R9", "vma released on strobe high", per_vma_n, 1);
    repeat (15) begin
      @(negedge clk);
      chk(!mst_done && per_vma_n, "R9", "no completion after abort", mst_done, 0);
    end

    // R8 strobe held low after completion
    do_xfer(23'h0ABCDE, 16'h0000, 1'b1, 16'hC3C3, 2, 25);
    do_xfer(23'h000002, 16'h0000, 1'b1, 16'h3C3C, 1, 0);

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R7", "all expected completions seen", expq.size(), 0);
    finish_run();
  end
endmodule